// File: doc/BRIEF.md
# PLL Out-of-Lock Detector with Selectable Error Window

This block watches the two pulse outputs of a PLL phase comparator and decides whether the loop has lost lock. The pump-up and pump-down pulses are merged into one error pulse. The width of each error pulse is measured in cycles of a fast sampling clock, and the result is compared with a window chosen by a 2-bit selector. The selector offers four choices: detection off, a pass-through mode, a narrow window and a wide window. With the default 36 MHz sampling clock, the narrow window is 0.5 µs (18 cycles) and the wide window is 1 µs (36 cycles).

In pass-through mode the merged error pulse reaches the status pin directly as a low level. In the two windowed modes the pin is pulled low only after about 1 ms of continuous or repeated over-window errors. Once pulled low, it stays low until about 1 ms has passed without a violation. This gives an unlock indication that is delayed and stretched by 1 to 2 ms.

The pin is open-drain. The block drives it through two outputs: an enable for the pull-down driver and a drive-low level. A release input frees the pin whatever the lock state, so the same board net can be shared with other devices. A change of the selector discards all measurements in progress.

Top module: `pll_unlock_watch`

## Requirements
- R1: With `win_sel` = 2'b00, detection is stopped: `pin_oe` and `pin_drive_low` are 0 at the clock edge after that setting is sampled, whatever happens on the comparator inputs.
- R2: With `win_sel` = 2'b01 and `pin_release` = 0, `pin_drive_low` at each clock edge equals `pd_up | pd_dn` as sampled at the previous edge.
- R3: With `win_sel` = 2'b10, an error pulse of at most WIN_NARROW consecutive high samples is never a violation. A pulse of WIN_NARROW+1 or more samples is a violation.
- R4: With `win_sel` = 2'b11, the same rule as R3 applies with WIN_WIDE in place of WIN_NARROW.
- R5: In a windowed mode, the pin goes low only once the interval from the first violation is between MS_TICKS-1 and MS_TICKS tick periods (one tick period is TICK_DIV cycles), and only if violations keep recurring within that interval. A lone violation never pulls the pin low.
- R6: After the pin goes low in a windowed mode, it stays low until MS_TICKS-1 to MS_TICKS tick periods have passed since the last violation. It is then released.
- R7: While `pin_release` = 1, both `pin_oe` and `pin_drive_low` are 0 from the next edge on, and the detector state is kept. When `pin_release` returns to 0, a standing unlock shows again.
- R8: When detection is on and `pin_release` = 0, `pin_oe` is 1 even while the loop is locked. `pin_drive_low` is never 1 while `pin_oe` is 0.
- R9: At the edge where `win_sel` takes a new value, the width counter, the timers and the unlock state are cleared, so `pin_drive_low` drops to 0 in a windowed mode.
- R10: A synchronous active-low reset clears all counters and state and releases the pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock (36 MHz default) |
| rst_n | input | 1 | Synchronous active-low reset |
| pd_up | input | 1 | Phase comparator pump-up pulse, synchronous to clk |
| pd_dn | input | 1 | Phase comparator pump-down pulse, synchronous to clk |
| win_sel | input | 2 | 00 off, 01 pass-through, 10 narrow window, 11 wide window |
| pin_release | input | 1 | 1 forces the status pin open |
| pin_oe | output | 1 | Pull-down driver armed (0 = high impedance) |
| pin_drive_low | output | 1 | Pin pulled low (loop reported unlocked) |

## Verification
The bench puts pulses of exactly the window width next to pulses one sample wider, in both windowed modes. A counter that is off by one would flag the first kind or miss the second. A single over-window pulse must stay silent, and steady trains must assert the pin only inside the 1 ms bound. A detector without the qualify delay would pull the pin low at once, and one that lets the hold timer lose to the qualify timer would report a lone glitch. The stretch after the last violation is timed as well, which catches a release that comes early. Changing the selector while unlocked, and toggling the release input, must clear or mask the pin in the very next cycle, and the release must not lose the underlying state.

// File: rtl/pul_pkg.sv
// Package pul_pkg
// Shared encodings for the PLL out-of-lock detector.
// Assumes: the 2-bit selector encoding is fixed by the control word layout.
package pul_pkg;

    // Detection mode selector
    typedef enum logic [1:0] {
        SEL_OFF    = 2'b00,
        SEL_DIRECT = 2'b01,
        SEL_NARROW = 2'b10,
        SEL_WIDE   = 2'b11
    } sel_e;

    // Delay/hold state of the windowed detector
    typedef enum logic [1:0] {
        HS_LOCK = 2'b00,
        HS_PEND = 2'b01,
        HS_UNL  = 2'b10
    } hold_e;

endpackage

// File: rtl/pul_width_meter.sv
// Module pul_width_meter
// Counts consecutive high samples of the merged error pulse. Flags a
// violation on every sample that lies beyond the selected window limit.
// Assumes: err is synchronous to clk; clr wins over counting.
module pul_width_meter #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             err,
    input  logic [CNT_W-1:0] limit,
    output logic             viol
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] run_cnt;   // number of earlier consecutive high samples

    // Purpose: track the length of the current error pulse, saturating
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            run_cnt <= '0;
        end else if (err) begin
            if (run_cnt != CNT_MAX) run_cnt <= run_cnt + 1'b1;
        end else begin
            run_cnt <= '0;
        end
    end

    // Purpose: a sample is a violation once limit samples already precede it
    always_comb begin
        viol = err && (run_cnt >= limit) && !clr;
    end

endmodule

// File: rtl/pul_hold_fsm.sv
// Module pul_hold_fsm
// Turns violations into a delayed, stretched unlock state. Violations must
// recur for MS_TICKS ticks before unlock is declared. Unlock is held until
// MS_TICKS ticks pass without a violation.
// Assumes: MS_TICKS >= 2; a tick is one pulse every TICK_DIV clocks.
module pul_hold_fsm
    import pul_pkg::*;
#(
    parameter int TICK_DIV = 36,
    parameter int MS_TICKS = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic viol,
    output logic unl_nxt
);
    localparam int TW = $clog2(MS_TICKS + 1);
    localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [TW-1:0] TLAST = TW'(MS_TICKS - 1);

    logic          tick;
    hold_e         st, st_n;
    logic [TW-1:0] qual_t, qual_n;   // ticks since first violation
    logic [TW-1:0] quiet_t, quiet_n; // ticks since last violation

    // Prescaler variant chosen by TICK_DIV
    generate
        if (TICK_DIV == 1) begin : g_nodiv
            assign tick = 1'b1;
        end else begin : g_div
            localparam logic [PW-1:0] PLAST = PW'(TICK_DIV - 1);
            logic [PW-1:0] pre_cnt;

            // Purpose: free-running divider, restarted on clear
            always_ff @(posedge clk) begin
                if (!rst_n || clr)         pre_cnt <= '0;
                else if (pre_cnt == PLAST) pre_cnt <= '0;
                else                       pre_cnt <= pre_cnt + 1'b1;
            end
            assign tick = (pre_cnt == PLAST);
        end
    endgenerate

    // Purpose: next-state and timer logic for qualify and hold phases
    always_comb begin
        st_n    = st;
        qual_n  = qual_t;
        quiet_n = quiet_t;
        if (clr) begin
            st_n    = HS_LOCK;
            qual_n  = '0;
            quiet_n = '0;
        end else begin
            unique case (st)
                HS_LOCK: begin
                    if (viol) begin
                        st_n    = HS_PEND;
                        qual_n  = '0;
                        quiet_n = '0;
                    end
                end
                HS_PEND: begin
                    if (viol) begin
                        quiet_n = '0;
                    end else if (tick) begin
                        if (quiet_t == TLAST) st_n = HS_LOCK;
                        else                  quiet_n = quiet_t + 1'b1;
                    end
                    if (st_n == HS_PEND && tick) begin
                        if (qual_t == TLAST) st_n = HS_UNL;
                        else                 qual_n = qual_t + 1'b1;
                    end
                end
                HS_UNL: begin
                    if (viol) begin
                        quiet_n = '0;
                    end else if (tick) begin
                        if (quiet_t == TLAST) begin
                            st_n    = HS_LOCK;
                            quiet_n = '0;
                        end else begin
                            quiet_n = quiet_t + 1'b1;
                        end
                    end
                end
                default: st_n = HS_LOCK;
            endcase
        end
    end

    // Purpose: state and timer registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= HS_LOCK;
            qual_t  <= '0;
            quiet_t <= '0;
        end else begin
            st      <= st_n;
            qual_t  <= qual_n;
            quiet_t <= quiet_n;
        end
    end

    // Purpose: expose the post-edge unlock state to the pin stage
    always_comb begin
        unl_nxt = (st_n == HS_UNL);
    end

endmodule

// File: rtl/pul_pin_stage.sv
// Module pul_pin_stage
// Registers the open-drain pin controls from the mode, the release input
// and the unlock indication.
// Assumes: unl_nxt already reflects any clear performed this cycle.
module pul_pin_stage
    import pul_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  sel_e sel,
    input  logic release_pin,
    input  logic err,
    input  logic unl_nxt,
    output logic pin_oe,
    output logic pin_drive_low
);
    logic armed;
    logic indicate;

    // Purpose: decide whether the driver is armed and what it reports
    always_comb begin
        armed = (sel != SEL_OFF) && !release_pin;
        unique case (sel)
            SEL_DIRECT:             indicate = err;
            SEL_NARROW, SEL_WIDE:   indicate = unl_nxt;
            default:                indicate = 1'b0;
        endcase
    end

    // Purpose: output registers, released in reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_oe        <= 1'b0;
            pin_drive_low <= 1'b0;
        end else begin
            pin_oe        <= armed;
            pin_drive_low <= armed && indicate;
        end
    end

endmodule

// File: rtl/pll_unlock_watch.sv
// Module pll_unlock_watch (top)
// Out-of-lock detector: merges the comparator pulses, measures the width,
// qualifies violations over time and drives the open-drain status pin.
// Assumes: pd_up/pd_dn are synchronous to clk; window limits are in clk
// cycles; a tick period times MS_TICKS is about 1 ms.
module pll_unlock_watch
    import pul_pkg::*;
#(
    parameter int WIN_NARROW = 18,
    parameter int WIN_WIDE   = 36,
    parameter int TICK_DIV   = 36,
    parameter int MS_TICKS   = 1000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pd_up,
    input  logic       pd_dn,
    input  logic [1:0] win_sel,
    input  logic       pin_release,
    output logic       pin_oe,
    output logic       pin_drive_low
);
    localparam int CNT_W = $clog2(WIN_WIDE + 2);
    localparam logic [CNT_W-1:0] LIM_NARROW = CNT_W'(WIN_NARROW);
    localparam logic [CNT_W-1:0] LIM_WIDE   = CNT_W'(WIN_WIDE);

    sel_e             sel, sel_q;
    logic             err;
    logic             sel_chg;
    logic             clr_meas;
    logic [CNT_W-1:0] limit;
    logic             viol;
    logic             unl_nxt;

    // Purpose: decode the selector and merge the comparator pulses
    always_comb begin
        sel      = sel_e'(win_sel);
        err      = pd_up | pd_dn;
        sel_chg  = (sel != sel_q);
        clr_meas = sel_chg || !(sel == SEL_NARROW || sel == SEL_WIDE);
        limit    = (sel == SEL_WIDE) ? LIM_WIDE : LIM_NARROW;
    end

    // Purpose: remember the selector to spot changes
    always_ff @(posedge clk) begin
        if (!rst_n) sel_q <= SEL_OFF;
        else        sel_q <= sel;
    end

    pul_width_meter #(
        .CNT_W (CNT_W)
    ) i_meter (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr_meas),
        .err   (err),
        .limit (limit),
        .viol  (viol)
    );

    pul_hold_fsm #(
        .TICK_DIV (TICK_DIV),
        .MS_TICKS (MS_TICKS)
    ) i_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr_meas),
        .viol    (viol),
        .unl_nxt (unl_nxt)
    );

    pul_pin_stage i_pin (
        .clk           (clk),
        .rst_n         (rst_n),
        .sel           (sel),
        .release_pin   (pin_release),
        .err           (err),
        .unl_nxt       (unl_nxt),
        .pin_oe        (pin_oe),
        .pin_drive_low (pin_drive_low)
    );

endmodule

// File: rtl/pll_unlock_watch_chk.sv
// Module pll_unlock_watch_chk
// Port-level properties of the out-of-lock detector, bound to the top.
module pll_unlock_watch_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       pd_up,
    input logic       pd_dn,
    input logic [1:0] win_sel,
    input logic       pin_release,
    input logic       pin_oe,
    input logic       pin_drive_low
);

    // R1: detection off releases the pin
    a_r1_off_released: assert property (@(posedge clk) disable iff (!rst_n)
        (win_sel == 2'b00) |=> (!pin_oe && !pin_drive_low));

    // R2: pass-through mode mirrors the merged error one cycle later
    a_r2_direct_follow: assert property (@(posedge clk) disable iff (!rst_n)
        (win_sel == 2'b01 && !pin_release) |=> (pin_drive_low == $past(pd_up | pd_dn)));

    // R7: release input forces the pin open
    a_r7_release_open: assert property (@(posedge clk) disable iff (!rst_n)
        pin_release |=> (!pin_oe && !pin_drive_low));

    // R8: pulling low only with the driver armed
    a_r8_low_needs_oe: assert property (@(posedge clk) disable iff (!rst_n)
        pin_drive_low |-> pin_oe);

    // R8: armed whenever detection on and not released
    a_r8_armed: assert property (@(posedge clk) disable iff (!rst_n)
        (win_sel != 2'b00 && !pin_release) |=> pin_oe);

endmodule

bind pll_unlock_watch pll_unlock_watch_chk i_chk (.*);

// File: tb/test_pll_unlock_watch.sv
module test_pll_unlock_watch;

    localparam int WN  = 18;
    localparam int WW  = 36;
    localparam int DIV = 8;
    localparam int MST = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pd_up = 1'b0;
    logic       pd_dn = 1'b0;
    logic [1:0] win_sel = 2'b00;
    logic       pin_release = 1'b0;
    logic       pin_oe;
    logic       pin_drive_low;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    pll_unlock_watch #(
        .WIN_NARROW (WN),
        .WIN_WIDE   (WW),
        .TICK_DIV   (DIV),
        .MS_TICKS   (MST)
    ) i_pll_unlock_watch (
        .clk           (clk),
        .rst_n         (rst_n),
        .pd_up         (pd_up),
        .pd_dn         (pd_dn),
        .win_sel       (win_sel),
        .pin_release   (pin_release),
        .pin_oe        (pin_oe),
        .pin_drive_low (pin_drive_low)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Drive a periodic pulse train, record first low sample and low count
    task automatic run_pat(input int width, input int period, input int ncyc,
                           input bit use_dn, output int first_low, output int n_low);
        first_low = -1;
        n_low = 0;
        for (int c = 0; c < ncyc; c++) begin
            if (use_dn) pd_dn = ((c % period) < width);
            else        pd_up = ((c % period) < width);
            @(negedge clk);
            if (pin_drive_low) begin
                n_low++;
                if (first_low < 0) first_low = c;
            end
        end
        pd_up = 1'b0;
        pd_dn = 1'b0;
    endtask

    // Idle inputs, record first sample where the pin is no longer low
    task automatic run_idle(input int ncyc, output int first_rel);
        first_rel = -1;
        pd_up = 1'b0;
        pd_dn = 1'b0;
        for (int c = 0; c < ncyc; c++) begin
            @(negedge clk);
            if (!pin_drive_low && first_rel < 0) first_rel = c;
        end
    endtask

    task automatic set_mode(input logic [1:0] m);
        int dummy;
        win_sel = m;
        run_idle(4, dummy);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        pd_up = 1'b1;
        win_sel = 2'b01;
        repeat (3) @(negedge clk);
        chk(pin_oe == 1'b0, "R10 oe in reset", pin_oe, 0);
        chk(pin_drive_low == 1'b0, "R10 low in reset", pin_drive_low, 0);
        pd_up = 1'b0;
        win_sel = 2'b00;
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_off;
        int fl, nl;
        set_mode(2'b00);
        run_pat(40, 41, 80, 1'b0, fl, nl);
        chk(nl == 0, "R1 off mode never low", nl, 0);
        chk(pin_oe == 1'b0, "R1 off mode oe", pin_oe, 0);
    endtask

    task automatic t_direct;
        int mism = 0;
        set_mode(2'b01);
        chk(pin_oe == 1'b1, "R8 armed in direct", pin_oe, 1);
        for (int c = 0; c < 40; c++) begin
            bit e;
            e = ((c % 7) < 3) || (c % 11 == 5);
            pd_up = ((c % 7) < 3);
            pd_dn = (c % 11 == 5);
            @(negedge clk);
            if (pin_drive_low != e) mism++;
        end
        pd_up = 0; pd_dn = 0;
        chk(mism == 0, "R2 direct follows up|dn", mism, 0);
    endtask

    task automatic t_narrow_edge;
        int fl, nl;
        set_mode(2'b10);
        chk(pin_oe == 1'b1 && pin_drive_low == 1'b0, "R8 armed and locked", pin_drive_low, 0);
        run_pat(WN, 40, 400, 1'b0, fl, nl);
        chk(nl == 0, "R3 pulse of window width is no violation", nl, 0);
        run_pat(WN + 7, 40, 400, 1'b1, fl, nl);
        // first violation at c=WN, unlock after 121..128 more cycles
        chk(fl >= WN + 119 && fl <= WN + 130, "R3 R5 over-window train unlocks in 1 ms", fl, WN + 125);
        run_idle(200, fl);
        // last violation 16 cycles before idle start; release 121..128 after
        chk(fl >= 100 && fl <= 116, "R6 held about 1 ms after last violation", fl, 108);
    endtask

    task automatic t_single;
        int fl, nl;
        set_mode(2'b10);
        run_pat(WN + 2, 400, 300, 1'b0, fl, nl);
        chk(nl == 0, "R5 lone violation never unlocks", nl, 0);
    endtask

    task automatic t_wide;
        int fl, nl;
        set_mode(2'b11);
        run_pat(WW, 60, 600, 1'b0, fl, nl);
        chk(nl == 0, "R4 pulse of wide window width is no violation", nl, 0);
        run_pat(WW + 1, 60, 600, 1'b0, fl, nl);
        chk(fl >= WW + 119 && fl <= WW + 130, "R4 one sample over wide window unlocks", fl, WW + 125);
        set_mode(2'b00);
    endtask

    task automatic t_release_and_change;
        int fl, nl;
        set_mode(2'b10);
        pd_up = 1'b1;
        fl = -1;
        for (int c = 0; c < 200; c++) begin
            @(negedge clk);
            if (pin_drive_low && fl < 0) fl = c;
        end
        chk(fl >= WN + 119 && fl <= WN + 130, "R5 steady error unlocks", fl, WN + 125);
        pin_release = 1'b1;
        @(negedge clk);
        chk(pin_oe == 1'b0 && pin_drive_low == 1'b0, "R7 release opens pin", pin_drive_low, 0);
        repeat (5) @(negedge clk);
        pin_release = 1'b0;
        @(negedge clk);
        chk(pin_drive_low == 1'b1, "R7 unlock shows again after release", pin_drive_low, 1);
        win_sel = 2'b11;
        @(negedge clk);
        chk(pin_drive_low == 1'b0, "R9 mode change clears unlock", pin_drive_low, 1'b0);
        nl = 0;
        for (int c = 0; c < 100; c++) begin
            @(negedge clk);
            if (pin_drive_low) nl++;
        end
        chk(nl == 0, "R9 qualify restarts after change", nl, 0);
        pd_up = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk(pin_oe == 1'b0 && pin_drive_low == 1'b0, "R10 reset releases pin", pin_oe, 0);
        set_mode(2'b00);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_off();
        t_direct();
        t_narrow_edge();
        t_single();
        t_wide();
        t_release_and_change();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule